// File: doc/BRIEF.md
# Descriptor Ring Completion Tracker

This block keeps the hardware side of the bookkeeping for two descriptor rings that a packet engine shares with software. The receive ring has 512 entries and the transmit ring has 128. Software posts receive buffers or queues transmit descriptors by writing a count to a per-ring doorbell. The engine reports each finished descriptor on an event port. The block moves a per-ring engine pointer, keeps the number of posted descriptors that have not yet been consumed, and counts completions. Software then retires those completions by writing an amount to subtract from the completion count.

Each ring compares its completion count against a programmable high-watermark. The result feeds an interrupt status bit that software clears by writing a one to it, and a per-ring enable gates that bit onto the interrupt line. On the receive side a multi-buffer packet counts as a single completion, because only the buffer that ends the packet increments the count. Each ring also exposes the address of the descriptor the engine will consume next. That address is built from a base held in units of 8-byte entries plus the engine pointer.

Top module: `drt_top`

## Requirements
- R1: After reset every pointer, fill level, completion count, watermark, interrupt status and interrupt enable is zero, and `irq` and `ovfErr` are low.
- R2: A write of N to the doorbell (field 1) adds N to the ring's outstanding level and advances its post pointer modulo the ring size. A doorbell that would raise the outstanding level above the ring size is discarded in whole. Reading field 1 returns the post pointer. Reading field 4 returns the engine pointer in bits 31:16 and the outstanding level in bits 15:0.
- R3: A completion event on a ring whose outstanding level is zero changes no pointer, level or count. `ovfErr` is high for exactly the one cycle after that event.
- R4: An accepted event lowers the outstanding level by one and advances the engine pointer modulo the ring size. The fetch address output equals the base plus the engine pointer.
- R5: A receive event whose 5-bit code is 0x10 (packet continues) consumes a buffer without raising the completion count. Code 0x0F (packet complete) and every other code raise it by one. Transmit events always raise it.
- R6: Writing N to the completion count (field 2) subtracts N from it, and the count saturates at zero when N exceeds it.
- R7: The receive threshold holds while the count is greater than the watermark (field 3), so a watermark of 0 fires on every packet. The transmit threshold holds while the count is at least the watermark and at least 1.
- R8: Interrupt status (field 6) has the receive bit at bit 0 and the transmit bit at bit 1. A threshold that holds sets its bit one clock later. Writing 1 to a bit clears it for one cycle, and the bit sets again on the next clock if the threshold still holds.
- R9: `irq` is high exactly when some status bit is set and its enable bit is set. The enable register is field 7 and uses the same bit positions as the status register.
- R10: Field 0 stores the ring base in bits 23:0. A read of field 0 returns that base together with log2 of the ring size in bits 27:24, which is 9 for receive and 7 for transmit.

Register addresses are 4 bits wide. Bit 3 selects the ring (0 receive, 1 transmit) and bits 2:0 select the field. Fields 6 and 7 are shared by both rings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address: ring select in bit 3, field in bits 2:0 |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Combinational read data for regAddr |
| evtValid | input | 1 | Engine completion event |
| evtTx | input | 1 | Event ring: 0 receive, 1 transmit |
| evtCode | input | 5 | Completion code of the event |
| irq | output | 1 | Interrupt request |
| ovfErr | output | 1 | One-cycle flag for an event on an empty ring |
| rxFetchAddr | output | 24 | Next receive descriptor address in 8-byte units |
| txFetchAddr | output | 24 | Next transmit descriptor address in 8-byte units |

## Verification
The bench fires an event at an empty ring. A design that let it through would wrap the outstanding level to all ones and count a phantom completion. It posts exactly a full ring and then one more descriptor. A capacity check that was off by one would accept the extra one or refuse the full ring. It runs the receive engine pointer across the 512-entry boundary and feeds it continuation codes. A wrong mask would break the fetch address, and counting continuation buffers would raise the interrupt on partial packets. It acknowledges more completions than exist, clears a status bit while its threshold still holds, and sets the watermark right at the count. These catch a count that wraps instead of saturating, a status bit that either never clears or stays clear, and an off-by-one in either ring's comparison.

// File: rtl/drt_pkg.sv
package drt_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 24;
  localparam int FLD_W  = 16;
  localparam int CODE_W = 5;
  localparam int N_RING = 2;

  localparam logic [CODE_W-1:0] CODE_DONE = 5'h0F;
  localparam logic [CODE_W-1:0] CODE_MORE = 5'h10;

  localparam logic [2:0] REG_CFG   = 3'd0;
  localparam logic [2:0] REG_DOOR  = 3'd1;
  localparam logic [2:0] REG_COMP  = 3'd2;
  localparam logic [2:0] REG_HWM   = 3'd3;
  localparam logic [2:0] REG_LEVEL = 3'd4;
  localparam logic [2:0] REG_STAT  = 3'd6;
  localparam logic [2:0] REG_EN    = 3'd7;

  typedef struct packed {
    logic              cfgWe;
    logic              doorWe;
    logic              ackWe;
    logic              hwmWe;
    logic [DATA_W-1:0] wdata;
    logic              evtValid;
    logic [CODE_W-1:0] evtCode;
  } ringCmd_t;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] fetchAddr;
    logic [3:0]        sizeLg;
    logic [FLD_W-1:0]  postPtr;
    logic [FLD_W-1:0]  engPtr;
    logic [FLD_W-1:0]  outstanding;
    logic [FLD_W-1:0]  compCnt;
    logic [FLD_W-1:0]  hwm;
    logic              thresh;
    logic              ovf;
  } ringView_t;
endpackage

// File: rtl/drt_ring_dp.sv
module drt_ring_dp
  import drt_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter bit IS_RX = 1'b1
) (
  input  logic      clk,
  input  logic      rstN,
  input  ringCmd_t  cmd,
  output ringView_t view
);
  localparam int PW = $clog2(DEPTH);

  logic [ADDR_W-1:0] base;
  logic [PW-1:0]     postPtr;
  logic [PW-1:0]     engPtr;
  logic [FLD_W-1:0]  outst;
  logic [FLD_W-1:0]  comp;
  logic [FLD_W-1:0]  hwm;
  logic              ovfQ;

  logic [FLD_W-1:0]  amount;
  logic [FLD_W:0]    doorSum;
  logic              doorOk;
  logic              consume;
  logic              ovfNow;
  logic              pktEnd;
  logic [FLD_W-1:0]  outstNext;
  logic [FLD_W-1:0]  compInc;
  logic [FLD_W-1:0]  compNext;
  logic              thresh;

  always_comb begin
    amount    = cmd.wdata[FLD_W-1:0];
    doorSum   = {1'b0, outst} + {1'b0, amount};
    doorOk    = cmd.doorWe && (doorSum <= (FLD_W+1)'(DEPTH));
    consume   = cmd.evtValid && (outst != '0);
    ovfNow    = cmd.evtValid && (outst == '0);
    pktEnd    = consume && (!IS_RX || (cmd.evtCode != CODE_MORE));
    outstNext = outst;
    if (doorOk)  outstNext = outstNext + amount;
    if (consume) outstNext = outstNext - FLD_W'(1);
    compInc = (pktEnd && (comp != '1)) ? comp + FLD_W'(1) : comp;
    if (cmd.ackWe) compNext = (compInc > amount) ? compInc - amount : '0;
    else           compNext = compInc;
    if (IS_RX) thresh = comp > hwm;
    else       thresh = (comp != '0) && (comp >= hwm);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      base    <= '0;
      postPtr <= '0;
      engPtr  <= '0;
      outst   <= '0;
      comp    <= '0;
      hwm     <= '0;
      ovfQ    <= 1'b0;
    end else begin
      if (cmd.cfgWe) base <= cmd.wdata[ADDR_W-1:0];
      if (doorOk)    postPtr <= postPtr + amount[PW-1:0];
      if (consume)   engPtr <= engPtr + PW'(1);
      if (cmd.hwmWe) hwm <= amount;
      outst <= outstNext;
      comp  <= compNext;
      ovfQ  <= ovfNow;
    end
  end

  always_comb begin
    view.base        = base;
    view.fetchAddr   = base + ADDR_W'(engPtr);
    view.sizeLg      = 4'(PW);
    view.postPtr     = FLD_W'(postPtr);
    view.engPtr      = FLD_W'(engPtr);
    view.outstanding = outst;
    view.compCnt     = comp;
    view.hwm         = hwm;
    view.thresh      = thresh;
    view.ovf         = ovfQ;
  end
endmodule

// File: rtl/drt_ctrl.sv
module drt_ctrl
  import drt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [3:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              evtValid,
  input  logic              evtTx,
  input  logic [CODE_W-1:0] evtCode,
  input  ringView_t         view [N_RING],
  output ringCmd_t          cmd [N_RING],
  output logic [DATA_W-1:0] regRdata,
  output logic              irq,
  output logic [N_RING-1:0] intStat,
  output logic [N_RING-1:0] intEn
);
  logic [2:0]        field;
  logic [N_RING-1:0] clrBits;
  ringView_t         sel;

  assign field = regAddr[2:0];

  for (genvar r = 0; r < N_RING; r++) begin : g_dec
    logic hit;
    assign hit = regWe && (regAddr[3] == 1'(r));
    assign cmd[r] = '{
      cfgWe:    hit && (field == REG_CFG),
      doorWe:   hit && (field == REG_DOOR),
      ackWe:    hit && (field == REG_COMP),
      hwmWe:    hit && (field == REG_HWM),
      wdata:    regWdata,
      evtValid: evtValid && (evtTx == 1'(r)),
      evtCode:  evtCode
    };
  end

  assign clrBits = (regWe && (field == REG_STAT)) ? regWdata[N_RING-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intStat <= '0;
      intEn   <= '0;
    end else begin
      for (int i = 0; i < N_RING; i++)
        intStat[i] <= clrBits[i] ? 1'b0 : (intStat[i] | view[i].thresh);
      if (regWe && (field == REG_EN)) intEn <= regWdata[N_RING-1:0];
    end
  end

  assign irq = |(intStat & intEn);

  always_comb begin
    sel = view[regAddr[3]];
    case (field)
      REG_CFG:   regRdata = DATA_W'({sel.sizeLg, sel.base});
      REG_DOOR:  regRdata = DATA_W'(sel.postPtr);
      REG_COMP:  regRdata = DATA_W'(sel.compCnt);
      REG_HWM:   regRdata = DATA_W'(sel.hwm);
      REG_LEVEL: regRdata = DATA_W'({sel.engPtr, sel.outstanding});
      REG_STAT:  regRdata = DATA_W'(intStat);
      REG_EN:    regRdata = DATA_W'(intEn);
      default:   regRdata = '0;
    endcase
  end
endmodule

// File: rtl/drt_top.sv
module drt_top
  import drt_pkg::*;
#(
  parameter int RX_DEPTH = 512,
  parameter int TX_DEPTH = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [3:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              evtValid,
  input  logic              evtTx,
  input  logic [CODE_W-1:0] evtCode,
  output logic              irq,
  output logic              ovfErr,
  output logic [ADDR_W-1:0] rxFetchAddr,
  output logic [ADDR_W-1:0] txFetchAddr
);
  ringCmd_t          cmd  [N_RING];
  ringView_t         view [N_RING];
  logic [N_RING-1:0] intStat;
  logic [N_RING-1:0] intEn;

  drt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .evtValid(evtValid), .evtTx(evtTx),
    .evtCode(evtCode), .view(view), .cmd(cmd), .regRdata(regRdata),
    .irq(irq), .intStat(intStat), .intEn(intEn)
  );

  for (genvar r = 0; r < N_RING; r++) begin : g_ring
    drt_ring_dp #(
      .DEPTH(r == 0 ? RX_DEPTH : TX_DEPTH),
      .IS_RX(r == 0)
    ) u_dp (
      .clk(clk), .rstN(rstN), .cmd(cmd[r]), .view(view[r])
    );
  end

  assign ovfErr      = view[0].ovf | view[1].ovf;
  assign rxFetchAddr = view[0].fetchAddr;
  assign txFetchAddr = view[1].fetchAddr;
endmodule

// File: rtl/drt_checker.sv
module drt_checker
  import drt_pkg::*;
#(
  parameter int RX_DEPTH = 512,
  parameter int TX_DEPTH = 128
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic [3:0]        regAddr,
  input logic [DATA_W-1:0] regWdata,
  input logic              evtValid,
  input logic              evtTx,
  input logic [CODE_W-1:0] evtCode,
  input logic              irq,
  input logic              ovfErr,
  input ringView_t         rxV,
  input ringView_t         txV,
  input logic [1:0]        stat,
  input logic [1:0]        en
);
  logic rxAck, rxEvt;
  assign rxAck = regWe && (regAddr == 4'h2);
  assign rxEvt = evtValid && !evtTx;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (rxV.outstanding <= FLD_W'(RX_DEPTH)) && (txV.outstanding <= FLD_W'(TX_DEPTH))); // R2

  AST_EMPTY_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (rxEvt && (rxV.outstanding == '0)) |=> ovfErr); // R3

  AST_EMPTY_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (rxEvt && (rxV.outstanding == '0) && !rxAck) |=> $stable(rxV.compCnt)); // R3

  AST_MORE_NO_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (rxEvt && (evtCode == CODE_MORE) && !rxAck) |=> $stable(rxV.compCnt)); // R5

  AST_ACK_SATURATE: assert property (@(posedge clk) disable iff (!rstN)
    (rxAck && !rxEvt && (regWdata[FLD_W-1:0] >= rxV.compCnt)) |=> (rxV.compCnt == '0)); // R6

  AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && (regAddr[2:0] == REG_STAT) && regWdata[0]) |=> !stat[0]); // R8

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (en == 2'b00) |-> !irq); // R9
endmodule

bind drt_top drt_checker #(.RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
  .regWdata(regWdata), .evtValid(evtValid), .evtTx(evtTx),
  .evtCode(evtCode), .irq(irq), .ovfErr(ovfErr),
  .rxV(view[0]), .txV(view[1]), .stat(intStat), .en(intEn)
);

// File: tb/tb_drt_top.sv
`timescale 1ns/1ps
module tb_drt_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        evtValid = 1'b0;
  logic        evtTx = 1'b0;
  logic [4:0]  evtCode = '0;
  logic        irq, ovfErr;
  logic [23:0] rxFetchAddr, txFetchAddr;

  int checks = 0;
  int failures = 0;
  logic [31:0] v;

  always #4 clk = ~clk;

  drt_top dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .evtValid(evtValid),
    .evtTx(evtTx), .evtCode(evtCode), .irq(irq), .ovfErr(ovfErr),
    .rxFetchAddr(rxFetchAddr), .txFetchAddr(txFetchAddr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk);
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic evt(input logic tx, input logic [4:0] code);
    @(negedge clk);
    evtValid = 1'b1; evtTx = tx; evtCode = code;
    @(posedge clk);
    @(negedge clk);
    evtValid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rd(4'h2, v); chk("R1 rx count", v, 0);
    rd(4'h4, v); chk("R1 rx level", v, 0);
    rd(4'h6, v); chk("R1 status", v, 0);
    rd(4'h7, v); chk("R1 enable", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 ovfErr", {31'b0, ovfErr}, 0);
    rd(4'h0, v); chk("R10 rx size field", v, 32'h0900_0000);
    rd(4'h8, v); chk("R10 tx size field", v, 32'h0700_0000);
  endtask

  task automatic t_empty_event();
    evt(1'b1, 5'h0F);
    chk("R3 ovfErr after empty event", {31'b0, ovfErr}, 1);
    idle(1);
    chk("R3 ovfErr one cycle", {31'b0, ovfErr}, 0);
    rd(4'hA, v); chk("R3 tx count unchanged", v, 0);
    rd(4'hC, v); chk("R3 tx level unchanged", v, 0);
    chk("R3 tx fetch unchanged", {8'b0, txFetchAddr}, 0);
  endtask

  task automatic t_cfg();
    wr(4'h0, 32'hFF00_1000);
    rd(4'h0, v); chk("R10 rx base readback", v, 32'h0900_1000);
    chk("R4 rx fetch at base", {8'b0, rxFetchAddr}, 32'h1000);
  endtask

  task automatic t_doorbell();
    wr(4'h1, 5);
    rd(4'h4, v); chk("R2 rx level after post", v, 32'h0000_0005);
    rd(4'h1, v); chk("R2 rx post ptr", v, 5);
    wr(4'h9, 129);
    rd(4'hC, v); chk("R2 tx oversize discarded", v, 0);
    wr(4'h9, 128);
    rd(4'hC, v); chk("R2 tx full ring accepted", v, 128);
    rd(4'h9, v); chk("R2 tx post ptr wraps", v, 0);
  endtask

  task automatic t_codes();
    evt(1'b0, 5'h10);
    rd(4'h2, v); chk("R5 continue code no count", v, 0);
    rd(4'h4, v); chk("R4 rx level/engine ptr", v, 32'h0001_0004);
    chk("R4 rx fetch advances", {8'b0, rxFetchAddr}, 32'h1001);
    evt(1'b0, 5'h0F);
    rd(4'h2, v); chk("R5 done code counts", v, 1);
    evt(1'b0, 5'h03);
    rd(4'h2, v); chk("R5 error code counts", v, 2);
    rd(4'h4, v); chk("R4 rx level after three", v, 32'h0003_0002);
  endtask

  task automatic t_ack();
    wr(4'h2, 1);
    rd(4'h2, v); chk("R6 partial ack", v, 1);
    wr(4'h2, 7);
    rd(4'h2, v); chk("R6 ack saturates", v, 0);
  endtask

  task automatic t_rx_watermark();
    wr(4'h6, 3);
    rd(4'h6, v); chk("R8 status cleared", v, 0);
    wr(4'h3, 1);
    evt(1'b0, 5'h0F);
    idle(2);
    rd(4'h6, v); chk("R7 rx count equal to hwm", v, 0);
    evt(1'b0, 5'h0F);
    idle(2);
    rd(4'h6, v); chk("R7 rx count above hwm", v, 1);
    chk("R9 irq masked", {31'b0, irq}, 0);
    wr(4'h7, 1);
    chk("R9 irq enabled", {31'b0, irq}, 1);
  endtask

  task automatic t_clear_relevel();
    wr(4'h6, 1);
    rd(4'h6, v); chk("R8 bit clear for one cycle", v, 0);
    chk("R9 irq drops with status", {31'b0, irq}, 0);
    idle(1);
    rd(4'h6, v); chk("R8 bit sets again", v, 1);
    chk("R9 irq returns", {31'b0, irq}, 1);
  endtask

  task automatic t_rx_wrap();
    wr(4'h1, 512);
    rd(4'h4, v); chk("R2 rx full ring", v, 32'h0005_0200);
    rd(4'h1, v); chk("R2 rx post ptr wraps", v, 5);
    wr(4'h1, 1);
    rd(4'h4, v); chk("R2 rx over-post discarded", v, 32'h0005_0200);
    for (int i = 0; i < 508; i++) evt(1'b0, 5'h10);
    rd(4'h4, v); chk("R4 rx engine ptr wraps", v, 32'h0001_0004);
    chk("R4 rx fetch after wrap", {8'b0, rxFetchAddr}, 32'h1001);
    rd(4'h2, v); chk("R5 continue codes leave count", v, 2);
  endtask

  task automatic t_tx_watermark();
    wr(4'hB, 2);
    evt(1'b1, 5'h00);
    idle(2);
    rd(4'h6, v); chk("R7 tx below hwm", v & 32'h2, 0);
    evt(1'b1, 5'h00);
    idle(2);
    rd(4'h6, v); chk("R7 tx at hwm", v & 32'h2, 2);
    chk("R4 tx fetch", {8'b0, txFetchAddr}, 2);
    rd(4'hC, v); chk("R4 tx level", v, 32'h0002_007E);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_empty_event();
    t_cfg();
    t_doorbell();
    t_codes();
    t_ack();
    t_rx_watermark();
    t_clear_relevel();
    t_rx_wrap();
    t_tx_watermark();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule